// File: doc/BRIEF.md
# Request/Acknowledge Handshake Assist Bridge

This block sits between simple polled CPU register writes and a target that speaks a level request / one-cycle acknowledge handshake. Software writes a start command together with the command fields (direction, address, write data). The bridge then raises the request and holds it with stable command fields. When the acknowledge pulse arrives, the bridge drops the request on its own and captures the target's read data. It also records completion in a sticky flag that software can poll at any pace, so a fleeting pulse cannot be missed.

A programmable cycle limit guards against a target that never answers. When the limit runs out, the bridge withdraws the request and ends the transaction with a sticky timeout flag. A start command that arrives before the previous transaction has been closed by software is discarded and recorded as an overrun. All three flags are cleared by writing one to their clear bits. Clearing the completion flag returns the bridge to idle and ready for the next command.

Top module: `hs_assist_bridge`

## Requirements
- R1: While reset is high and on the first cycle after it, tgt_req, sts_busy, sts_done, sts_timeout and sts_overrun are 0 and sts_rdata is 0.
- R2: A write with ctl_wr=1 and ctl_go=1 while idle makes tgt_req and sts_busy 1 from the next cycle, with tgt_wr, tgt_addr and tgt_wdata equal to the written ctl_op, ctl_addr and ctl_wdata.
- R3: Once raised, tgt_req stays 1, with tgt_wr, tgt_addr and tgt_wdata unchanged, until the cycle after an acknowledge or a timeout.
- R4: An acknowledge sampled while the request is high makes tgt_req and sts_busy 0 and sts_done 1 in the next cycle, and sts_rdata takes the value tgt_rdata had in the acknowledge cycle.
- R5: While busy or while sts_done is set, a start write issues no request and leaves the command outputs unchanged. It sets sts_overrun.
- R6: ctl_clr is write-one-to-clear with ctl_wr=1: bit 0 clears sts_done and returns the bridge to idle, bit 1 clears sts_timeout and bit 2 clears sts_overrun. When an overrun and a clear of bit 2 coincide, sts_overrun stays 1.
- R7: With a nonzero ctl_limit L latched at the start, a request that gets no acknowledge stays high for exactly L cycles. It then drops, with sts_done and sts_timeout both set to 1. A limit of 0 disables the timeout.
- R8: sts_rdata holds its value until the next accepted start, which resets it to 0. The same start clears sts_timeout.
- R9: An acknowledge that arrives while no request is outstanding changes neither sts_done nor sts_rdata.
- R10: An acknowledge in the last cycle allowed by the limit completes normally, with sts_timeout remaining 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | CPU control write strobe |
| ctl_go | input | 1 | Start command bit of the control write |
| ctl_op | input | 1 | Direction of the command, 1 = write to target |
| ctl_addr | input | AW | Command address |
| ctl_wdata | input | DW | Command write data |
| ctl_clr | input | 3 | Write-one-to-clear: bit 0 done, bit 1 timeout, bit 2 overrun |
| ctl_limit | input | TW | Timeout in request cycles, 0 = none; latched at start |
| sts_busy | output | 1 | Request outstanding |
| sts_done | output | 1 | Sticky completion flag |
| sts_timeout | output | 1 | Sticky timeout flag |
| sts_overrun | output | 1 | Sticky discarded-start flag |
| sts_rdata | output | DW | Captured read data |
| tgt_req | output | 1 | Level request to target |
| tgt_wr | output | 1 | Command direction to target |
| tgt_addr | output | AW | Command address to target |
| tgt_wdata | output | DW | Command write data to target |
| tgt_ack | input | 1 | One-cycle acknowledge from target |
| tgt_rdata | input | DW | Read data from target, valid with acknowledge |

## Verification
The bench tries the handshake with these patterns:
- an immediate acknowledge;
- short and long acknowledge delays with the timeout disabled;
- an acknowledge that lands exactly on the limit;
- a delay that exceeds the limit, including a limit of one cycle.

The number of request-high cycles and the captured data separate a normal completion from a timeout, and separate an off-by-one limit from a correct one. Directed cases cover the following:
- start writes while busy and while done is still set;
- an overrun coinciding with its own clear;
- a stray acknowledge while idle;
- clearing the timeout flag through a new start.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } hsb_state_e;

  localparam int CLR_W      = 3;
  localparam int CLR_DONE_B = 0;
  localparam int CLR_TMO_B  = 1;
  localparam int CLR_OVR_B  = 2;
endpackage

// File: rtl/hsb_timer.sv
module hsb_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] lim_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
    end else if (start) begin
      lim_q <= limit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  // Expires on the last request cycle the limit allows.
  assign expire = run && (lim_q != '0) && (cnt_q == lim_q - TW'(1));
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
  import hsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_wr,
  input  logic       clr_done,
  input  logic       ack,
  input  logic       expire,
  output hsb_state_e state,
  output logic       start,
  output logic       fin_ack,
  output logic       fin_tmo,
  output logic       go_reject,
  output logic       req_q
);
  hsb_state_e state_d;

  assign start     = go_wr && (state == ST_IDLE);
  assign go_reject = go_wr && (state != ST_IDLE);
  assign fin_ack   = (state == ST_REQ) && ack;
  assign fin_tmo   = (state == ST_REQ) && !ack && expire;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (start) state_d = ST_REQ;
      ST_REQ:  if (fin_ack || fin_tmo) state_d = ST_DONE;
      ST_DONE: if (clr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      req_q <= 1'b0;
    end else begin
      state <= state_d;
      req_q <= (state_d == ST_REQ);
    end
  end
endmodule

// File: rtl/hsb_flags.sv
module hsb_flags
  import hsb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             fin_ack,
  input  logic             fin_tmo,
  input  logic             go_reject,
  input  logic [CLR_W-1:0] clr,
  input  logic [DW-1:0]    rdata_in,
  output logic             done,
  output logic             tmo,
  output logic             ovr,
  output logic [DW-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      tmo   <= 1'b0;
      ovr   <= 1'b0;
      rdata <= '0;
    end else begin
      if (fin_ack || fin_tmo)   done <= 1'b1;
      else if (clr[CLR_DONE_B]) done <= 1'b0;

      if (start)               tmo <= 1'b0;
      else if (fin_tmo)        tmo <= 1'b1;
      else if (clr[CLR_TMO_B]) tmo <= 1'b0;

      if (go_reject)           ovr <= 1'b1;
      else if (clr[CLR_OVR_B]) ovr <= 1'b0;

      if (start)        rdata <= '0;
      else if (fin_ack) rdata <= rdata_in;
    end
  end
endmodule

// File: rtl/hs_assist_bridge.sv
module hs_assist_bridge
  import hsb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_go,
  input  logic             ctl_op,
  input  logic [AW-1:0]    ctl_addr,
  input  logic [DW-1:0]    ctl_wdata,
  input  logic [CLR_W-1:0] ctl_clr,
  input  logic [TW-1:0]    ctl_limit,
  output logic             sts_busy,
  output logic             sts_done,
  output logic             sts_timeout,
  output logic             sts_overrun,
  output logic [DW-1:0]    sts_rdata,
  output logic             tgt_req,
  output logic             tgt_wr,
  output logic [AW-1:0]    tgt_addr,
  output logic [DW-1:0]    tgt_wdata,
  input  logic             tgt_ack,
  input  logic [DW-1:0]    tgt_rdata
);
  hsb_state_e       state;
  logic             start, fin_ack, fin_tmo, go_reject, expire, req_q;
  logic [CLR_W-1:0] clr_eff;

  assign clr_eff = ctl_wr ? ctl_clr : '0;

  hsb_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .go_wr     (ctl_wr && ctl_go),
    .clr_done  (clr_eff[CLR_DONE_B]),
    .ack       (tgt_ack),
    .expire    (expire),
    .state     (state),
    .start     (start),
    .fin_ack   (fin_ack),
    .fin_tmo   (fin_tmo),
    .go_reject (go_reject),
    .req_q     (req_q)
  );

  hsb_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .run    (state == ST_REQ),
    .limit  (ctl_limit),
    .expire (expire)
  );

  hsb_flags #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fin_ack   (fin_ack),
    .fin_tmo   (fin_tmo),
    .go_reject (go_reject),
    .clr       (clr_eff),
    .rdata_in  (tgt_rdata),
    .done      (sts_done),
    .tmo       (sts_timeout),
    .ovr       (sts_overrun),
    .rdata     (sts_rdata)
  );

  // Command fields are captured only when a start is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_wr    <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
    end else if (start) begin
      tgt_wr    <= ctl_op;
      tgt_addr  <= ctl_addr;
      tgt_wdata <= ctl_wdata;
    end
  end

  assign tgt_req  = req_q;
  assign sts_busy = (state == ST_REQ);
endmodule

// File: rtl/hsb_chk.sv
module hsb_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_wr,
  input logic          ctl_go,
  input logic          sts_busy,
  input logic          sts_done,
  input logic          sts_timeout,
  input logic          sts_overrun,
  input logic          tgt_req,
  input logic [AW-1:0] tgt_addr,
  input logic [DW-1:0] tgt_wdata,
  input logic          tgt_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    tgt_req && !tgt_ack |=> tgt_req || sts_timeout); // R3
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    tgt_req |=> !tgt_req || ($stable(tgt_addr) && $stable(tgt_wdata))); // R3
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    tgt_req && tgt_ack |=> !tgt_req && sts_done && !sts_busy); // R4
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    sts_done |=> !tgt_req); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && ctl_go && (sts_busy || sts_done) |=> sts_overrun); // R5
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_timeout) |-> sts_done && !tgt_req); // R7
endmodule

bind hs_assist_bridge hsb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr      (ctl_wr),
  .ctl_go      (ctl_go),
  .sts_busy    (sts_busy),
  .sts_done    (sts_done),
  .sts_timeout (sts_timeout),
  .sts_overrun (sts_overrun),
  .tgt_req     (tgt_req),
  .tgt_addr    (tgt_addr),
  .tgt_wdata   (tgt_wdata),
  .tgt_ack     (tgt_ack)
);

// File: tb/hs_assist_bridge_tb.sv
module hs_assist_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int TW = 16;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [7:0]    dly;
    logic [DW-1:0] rdata;
    logic [TW-1:0] lim;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h10, 32'h0000_0001, 8'd0,  32'hA5A5_0001, 16'd0},
    '{1'b1, 8'h22, 32'h1111_2222, 8'd3,  32'h0000_1234, 16'd8},
    '{1'b0, 8'h33, 32'h3333_0000, 8'd4,  32'hBEEF_0033, 16'd5},
    '{1'b0, 8'h44, 32'h0000_0044, 8'd9,  32'hCAFE_0044, 16'd4},
    '{1'b1, 8'h55, 32'h5555_5555, 8'd0,  32'h0000_0055, 16'd1},
    '{1'b0, 8'h66, 32'h6666_0000, 8'd2,  32'h0000_0066, 16'd1},
    '{1'b1, 8'h77, 32'h7777_7777, 8'd20, 32'h7700_0077, 16'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 1'b0, ctl_go = 1'b0, ctl_op = 1'b0;
  logic [AW-1:0] ctl_addr = '0;
  logic [DW-1:0] ctl_wdata = '0;
  logic [2:0]    ctl_clr = '0;
  logic [TW-1:0] ctl_limit = '0;
  logic          sts_busy, sts_done, sts_timeout, sts_overrun;
  logic [DW-1:0] sts_rdata;
  logic          tgt_req, tgt_wr;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_wdata;
  logic          tgt_ack = 1'b0;
  logic [DW-1:0] tgt_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_assist_bridge #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_go(ctl_go), .ctl_op(ctl_op),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_clr(ctl_clr),
    .ctl_limit(ctl_limit), .sts_busy(sts_busy), .sts_done(sts_done),
    .sts_timeout(sts_timeout), .sts_overrun(sts_overrun), .sts_rdata(sts_rdata),
    .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one control write across a single rising edge; returns at the following falling edge.
  task automatic cpu_write(input logic go, input logic op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [2:0] clr, input logic [TW-1:0] lim);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_go = go; ctl_op = op; ctl_addr = a; ctl_wdata = d;
    ctl_clr = clr; ctl_limit = lim;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_go = 1'b0; ctl_clr = '0;
  endtask

  // Count request-high cycles; acknowledge in cycle dly+1 if the request is still up.
  task automatic wait_end(input int dly, input logic [DW-1:0] rd, output int n);
    n = 0;
    while (tgt_req && n < 1000) begin
      n++;
      if (n == dly + 1) begin
        tgt_ack = 1'b1; tgt_rdata = rd;
      end
      @(negedge clk);
      tgt_ack = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit tmo_exp;
    int ncyc;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 req",  {31'b0, tgt_req}, 0);
    check("R1 flags", {28'b0, sts_busy, sts_done, sts_timeout, sts_overrun}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after", {28'b0, sts_busy, sts_done, sts_timeout, tgt_req}, 0);
    check("R1 rdata", sts_rdata, 0);

    // Table of transactions: R2, R3, R4, R7, R10
    for (int i = 0; i < NV; i++) begin
      tmo_exp = (VECS[i].lim != 0) && (int'(VECS[i].dly) + 1 > int'(VECS[i].lim));
      ncyc    = tmo_exp ? int'(VECS[i].lim) : int'(VECS[i].dly) + 1;
      cpu_write(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].wdata, 3'b000, VECS[i].lim);
      check("R2 req",   {30'b0, tgt_req, sts_busy}, 32'd3);
      check("R2 cmd",   {23'b0, tgt_wr, tgt_addr}, {23'b0, VECS[i].wr, VECS[i].addr});
      check("R2 wdata", tgt_wdata, VECS[i].wdata);
      wait_end(int'(VECS[i].dly), VECS[i].rdata, n);
      check(tmo_exp ? "R7 cycles" : "R3 cycles", n, ncyc);
      check("R4 done",  {30'b0, sts_busy, sts_done}, 32'd1);
      check(tmo_exp ? "R7 timeout" : "R10 timeout", {31'b0, sts_timeout}, {31'b0, tmo_exp});
      check("R4 rdata", sts_rdata, tmo_exp ? '0 : VECS[i].rdata);
      cpu_write(1'b0, 1'b0, '0, '0, 3'b111, '0);
      check("R6 clear", {29'b0, sts_done, sts_timeout, sts_busy}, 0);
    end

    // R5: start while busy is discarded and sets overrun
    cpu_write(1'b1, 1'b0, 8'hA1, 32'h0A1, 3'b000, 16'd0);
    cpu_write(1'b1, 1'b1, 8'hB2, 32'h0B2, 3'b000, 16'd0);
    check("R5 busy ovr", {30'b0, sts_overrun, tgt_req}, 32'd3);
    check("R5 addr", {23'b0, tgt_wr, tgt_addr}, {23'b0, 1'b0, 8'hA1});
    wait_end(0, 32'h0000_00A1, n);
    check("R4 rdata2", sts_rdata, 32'h0000_00A1);
    // R6: overrun cleared alone
    cpu_write(1'b0, 1'b0, '0, '0, 3'b100, '0);
    check("R6 ovr clr", {30'b0, sts_overrun, sts_done}, 32'd1);
    // R5: start while done still set
    cpu_write(1'b1, 1'b0, 8'hC3, 32'h0C3, 3'b000, 16'd0);
    check("R5 done ovr", {30'b0, sts_overrun, tgt_req}, 32'd2);
    check("R5 addr2", {24'b0, tgt_addr}, 32'h0000_00A1);
    // R6: overrun set wins over its clear in the same write
    cpu_write(1'b1, 1'b0, 8'hC4, 32'h0C4, 3'b100, 16'd0);
    check("R6 set wins", {31'b0, sts_overrun}, 32'd1);
    cpu_write(1'b0, 1'b0, '0, '0, 3'b111, '0);

    // R7 then R8: timeout left set, only done cleared
    cpu_write(1'b1, 1'b0, 8'hD5, 32'h0D5, 3'b000, 16'd3);
    wait_end(50, 32'h1, n);
    check("R7 cyc3", n, 3);
    cpu_write(1'b0, 1'b0, '0, '0, 3'b001, '0);
    check("R6 tmo kept", {30'b0, sts_timeout, sts_done}, 32'd2);
    // R8: rdata held from earlier capture
    check("R8 held", sts_rdata, 32'h0);
    // R9: stray acknowledge in idle
    cpu_write(1'b1, 1'b0, 8'hE6, 32'h0E6, 3'b000, 16'd0);
    check("R8 tmo cleared", {31'b0, sts_timeout}, 0);
    wait_end(1, 32'h0000_E6E6, n);
    cpu_write(1'b0, 1'b0, '0, '0, 3'b001, '0);
    check("R8 held2", sts_rdata, 32'h0000_E6E6);
    @(negedge clk);
    tgt_ack = 1'b1; tgt_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    tgt_ack = 1'b0;
    check("R9 done", {30'b0, sts_done, tgt_req}, 0);
    check("R9 rdata", sts_rdata, 32'h0000_E6E6);
    // R8: next start resets rdata
    cpu_write(1'b1, 1'b0, 8'hF7, 32'h0F7, 3'b000, 16'd0);
    check("R8 start clr", sts_rdata, 0);
    wait_end(0, 32'h0F7, n);
    cpu_write(1'b0, 1'b0, '0, '0, 3'b111, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule